// File: doc/BRIEF.md
# Modulo Timer PWM Channel

This block is a counting timer that generates one pulse-width-modulated output. An up-counter advances once per prescaled tick and returns to zero after it reaches a programmable period value. The output is driven to its pulse level when the counter wraps. It is forced to the opposite level when the counter equals the compare value. The output never toggles on a compare, so a 0% duty cycle is exact, and the output corrects itself within one period after any disturbance.

Software controls the block through a small write port. The port holds a control word (stop, counter clear and prescaler select), the period value, two compare values and a channel configuration word (mode, restore-on-wrap and action select). In unbuffered mode the first compare value is used directly. In buffered mode the two compare values take turns being active: software writes the idle one, and the block changes over only at a period boundary. The output port reports which compare value is active.

Top module: `modulo_pwm_timer`

## Requirements
- R1: After reset the counter is stopped (control bit 0 = 1), the prescaler select is 0, the period value is all ones, both compare values are 0, the mode is 00, and `pwm_o`, `ovf_o` and `act_o` are 0.
- R2: Write address 0 is the control word, with stop in bit 0, clear in bit 1 and prescaler select in bits 4:2. The counter advances once every 2^S clock cycles, where S is the select value; values 6 and 7 both give a ratio of 64.
- R3: Address 1 holds the period value P. The counter steps 0, 1, …, P and then 0 again, so a period is P+1 ticks long. At each wrap `ovf_o` is high for exactly one cycle.
- R4: While the stop bit is 1, neither the counter nor the prescaler moves, `ovf_o` stays low and `pwm_o` holds its level.
- R5: Writing control with bit 1 set clears the counter and the prescaler in that same cycle, and the bit does not persist. After a clear that also starts the counter at ratio 1, the first `ovf_o` pulse appears P+1 cycles later.
- R6: Address 4 is the channel configuration, with mode in bits 1:0, restore-on-wrap in bit 2 and action select in bits 4:3. Action 10 drives the pin low on a compare and gives a high pulse. Action 11 drives it high on a compare and gives a low pulse. With restore-on-wrap set, the pin returns to the pulse level at each wrap, so the pulse lasts C ticks of every P+1, where C is the active compare value.
- R7: A compare takes priority over a wrap in the same tick. C = 0 therefore gives 0% duty, and C > P gives 100% duty.
- R8: With restore-on-wrap clear, a wrap does not change the pin.
- R9: Mode 01 is unbuffered. It uses the compare value at address 2, and a new value written there takes effect at once.
- R10: Mode 10 is buffered. Address 2 is compare 0 and address 3 is compare 1. The active index (`act_o`) flips only at a wrap, and only if the idle compare value was written since the last flip. A write is counted as idle when its index differs from the index that is active after that cycle.
- R11: In buffered mode, a write to the active compare value takes effect at once and does not schedule a flip.
- R12: With mode 00 or 11, or with action-select bit 4 clear, the pin holds its level. In any mode other than 10, `act_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 period, 2 compare 0, 3 compare 1, 4 channel config) |
| wr_data | input | CNT_W | Write data |
| pwm_o | output | 1 | PWM pin |
| ovf_o | output | 1 | One-cycle wrap pulse |
| act_o | output | 1 | Index of the active compare value |

## Verification
The assertions assume that reset is held for at least one clock edge before any write, and that writes arrive synchronously as one-cycle strobes. The stop-hold and clear properties also assume that control writes carry a defined clear bit. The bench follows the stop, clear, configure and start sequence whenever it lowers the period value. It does this in both the directed phase and the random phase, so the counter never sits above a new period value and has to run the full counter range before wrapping. Random writes otherwise reach every address, mode and action. This deliberately includes compare writes that land on a wrap cycle, which exercises the R10 flip rule at its edge.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_PER  = 3'd1;
   localparam logic [ADDR_W-1:0] A_CMP0 = 3'd2;
   localparam logic [ADDR_W-1:0] A_CMP1 = 3'd3;
   localparam logic [ADDR_W-1:0] A_CFG  = 3'd4;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'b00,
      MODE_UNBUF = 2'b01,
      MODE_BUF   = 2'b10,
      MODE_RSVD  = 2'b11
   } ch_mode_e;

   typedef struct packed {
      ch_mode_e   mode;
      logic       restore;
      logic [1:0] act;
   } ch_cfg_t;
endpackage

// File: rtl/mpt_prescale.sv
module mpt_prescale #(
   parameter int SEL_W   = 3,
   parameter int MAX_SEL = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PRE_W = (MAX_SEL < 1) ? 1 : MAX_SEL;

   generate
      if (MAX_SEL == 0) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         logic [PRE_W-1:0] pre_q;
         logic [PRE_W-1:0] mask;
         logic [SEL_W-1:0] eff;

         always_comb begin
            eff  = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
            mask = PRE_W'((32'd1 << eff) - 32'd1);
         end

         assign tick = run && ((pre_q & mask) == mask);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pre_q <= '0;
            else if (clr) pre_q <= '0;
            else if (run) pre_q <= pre_q + PRE_W'(1);
         end

         p_pre_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !clr) |=> $stable(pre_q));
         p_pre_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (pre_q == '0));
      end
   endgenerate
endmodule

// File: rtl/mpt_count.sv
module mpt_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic [CNT_W-1:0] per,
   output logic             ev,
   output logic             wrap,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             ovf_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;

   assign ev      = tick && !clr;
   assign wrap    = ev && (cnt_q == per);
   assign cnt_nxt = wrap ? '0 : cnt_q + CNT_W'(1);
   assign ovf_o   = ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= wrap;
         if (clr)     cnt_q <= '0;
         else if (ev) cnt_q <= cnt_nxt;
      end
   end

   p_ovf_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> (cnt_q == '0));
   p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(cnt_q));
   p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0 && !ovf_q));
endmodule

// File: rtl/mpt_channel.sv
module mpt_channel
   import mpt_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit HAS_BUF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  ch_cfg_t           cfg,
   input  logic              ev,
   input  logic              wrap,
   input  logic [CNT_W-1:0]  cnt_nxt,
   output logic              pin_o,
   output logic              act_o
);
   logic [CNT_W-1:0] cmp0_q;
   logic [CNT_W-1:0] cmp_eff;
   logic             act_nxt;
   logic             pin_q;
   logic             pwm_on;

   assign pwm_on = ((cfg.mode == MODE_UNBUF) || (cfg.mode == MODE_BUF)) && cfg.act[1];
   assign pin_o  = pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cmp0_q <= '0;
      else if (wr_en && wr_addr == A_CMP0)    cmp0_q <= wr_data;
   end

   generate
      if (HAS_BUF) begin : g_buf
         logic [CNT_W-1:0] cmp1_q;
         logic             act_q;
         logic             pend_q;
         logic             flip;
         logic             wr_idle;

         always_comb begin
            flip    = (cfg.mode == MODE_BUF) && wrap && pend_q;
            act_nxt = (cfg.mode != MODE_BUF) ? 1'b0 : (flip ? ~act_q : act_q);
            cmp_eff = act_nxt ? cmp1_q : cmp0_q;
            wr_idle = wr_en && (((wr_addr == A_CMP0) && act_nxt) ||
                                ((wr_addr == A_CMP1) && !act_nxt));
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cmp1_q <= '0;
               act_q  <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               if (wr_en && wr_addr == A_CMP1) cmp1_q <= wr_data;
               act_q  <= act_nxt;
               pend_q <= (pend_q && !flip) || wr_idle;
            end
         end

         assign act_o = act_q;

         p_act_only_at_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!wrap && cfg.mode == MODE_BUF) |=> $stable(act_q));
         p_act_zero_unbuf_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.mode != MODE_BUF) |=> !act_q);
      end else begin : g_single
         assign act_nxt = 1'b0;
         assign cmp_eff = cmp0_q;
         assign act_o   = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else if (pwm_on && ev) begin
         if (cnt_nxt == cmp_eff)        pin_q <= cfg.act[0];
         else if (wrap && cfg.restore)  pin_q <= ~cfg.act[0];
      end
   end

   p_pin_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_on || !ev) |=> $stable(pin_q));
   p_no_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_on && !cfg.restore && pin_q == cfg.act[0]) |=> (pin_q == $past(cfg.act[0])));
endmodule

// File: rtl/modulo_pwm_timer.sv
module modulo_pwm_timer
   import mpt_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int SEL_W   = 3,
   parameter int MAX_SEL = 6,
   parameter bit HAS_BUF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic              pwm_o,
   output logic              ovf_o,
   output logic              act_o
);
   localparam int SEL_LO = 2;
   localparam int SEL_HI = SEL_LO + SEL_W - 1;

   initial begin
      assert (CNT_W >= SEL_HI + 1 && CNT_W >= 5)
         else $error("CNT_W too narrow for control and config fields");
      assert (MAX_SEL >= 0 && MAX_SEL < (1 << SEL_W))
         else $error("MAX_SEL out of range for SEL_W");
   end

   logic             stop_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] per_q;
   ch_cfg_t          cfg_q;
   logic             clr;
   logic             tick;
   logic             ev;
   logic             wrap;
   logic [CNT_W-1:0] cnt_nxt;

   assign clr = wr_en && (wr_addr == A_CTRL) && wr_data[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b1;
         sel_q  <= '0;
         per_q  <= '1;
         cfg_q  <= '{mode: MODE_OFF, restore: 1'b0, act: 2'b00};
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL: begin
               stop_q <= wr_data[0];
               sel_q  <= wr_data[SEL_HI:SEL_LO];
            end
            A_PER:  per_q <= wr_data;
            A_CFG:  cfg_q <= '{mode: ch_mode_e'(wr_data[1:0]),
                               restore: wr_data[2], act: wr_data[4:3]};
            default: ;
         endcase
      end
   end

   mpt_prescale #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(!stop_q), .clr(clr), .sel(sel_q), .tick(tick)
   );

   mpt_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .per(per_q),
      .ev(ev), .wrap(wrap), .cnt_nxt(cnt_nxt), .ovf_o(ovf_o)
   );

   mpt_channel #(.CNT_W(CNT_W), .HAS_BUF(HAS_BUF)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cfg(cfg_q), .ev(ev), .wrap(wrap), .cnt_nxt(cnt_nxt),
      .pin_o(pwm_o), .act_o(act_o)
   );

   p_stop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !wr_en) |=> (!ovf_o && $stable(pwm_o)));
endmodule

// File: tb/tb_modulo_pwm_timer.sv
module tb_modulo_pwm_timer;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        pwm_o, ovf_o, act_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   modulo_pwm_timer dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pwm_o(pwm_o), .ovf_o(ovf_o), .act_o(act_o)
   );

   always #(CLK_P/2) clk = ~clk;

   // behavioural reference state
   int m_stop, m_sel, m_per, m_cmp0, m_cmp1, m_mode, m_rest, m_act_sel;
   int m_cnt, m_pre, m_pin, m_ovf, m_act, m_pend;

   always @(posedge clk) begin
      int ratio, eff, nxt, ce, act_n, pend_n;
      bit run, clr, tick, ev, wrp;
      if (!rst_n) begin
         m_stop = 1; m_sel = 0; m_per = 65535; m_cmp0 = 0; m_cmp1 = 0;
         m_mode = 0; m_rest = 0; m_act_sel = 0;
         m_cnt = 0; m_pre = 0; m_pin = 0; m_ovf = 0; m_act = 0; m_pend = 0;
      end else begin
         run   = (m_stop == 0);
         clr   = wr_en && wr_addr == 3'd0 && wr_data[1];
         eff   = (m_sel > 6) ? 6 : m_sel;
         ratio = 1 << eff;
         tick  = run && ((m_pre % ratio) == ratio - 1);
         ev    = tick && !clr;
         wrp   = ev && (m_cnt == m_per);
         nxt   = wrp ? 0 : ((m_cnt + 1) % 65536);
         if (m_mode != 2) act_n = 0;
         else if (wrp && m_pend != 0) act_n = 1 - m_act;
         else act_n = m_act;
         pend_n = (m_mode == 2 && wrp && m_pend != 0) ? 0 : m_pend;
         ce = (act_n != 0) ? m_cmp1 : m_cmp0;
         if ((m_mode == 1 || m_mode == 2) && (m_act_sel / 2) == 1 && ev) begin
            if (nxt == ce) m_pin = m_act_sel % 2;
            else if (wrp && m_rest != 0) m_pin = 1 - (m_act_sel % 2);
         end
         m_ovf = wrp;
         if (clr) begin m_cnt = 0; m_pre = 0; end
         else begin
            if (run) m_pre = (m_pre + 1) % 64;
            if (ev) m_cnt = nxt;
         end
         m_act = act_n;
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin m_stop = wr_data[0]; m_sel = int'(wr_data[4:2]); end
               3'd1: m_per = int'(wr_data);
               3'd2: begin m_cmp0 = int'(wr_data); if (act_n != 0) pend_n = 1; end
               3'd3: begin m_cmp1 = int'(wr_data); if (act_n != 1) pend_n = 1; end
               3'd4: begin m_mode = int'(wr_data[1:0]); m_rest = wr_data[2];
                           m_act_sel = int'(wr_data[4:3]); end
               default: ;
            endcase
         end
         m_pend = pend_n;
      end
   end

   // cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (int'(pwm_o) != m_pin) begin
            n_bad++; $display("FAIL R6 pwm_o got %0d exp %0d at %0t", pwm_o, m_pin, $time);
         end
         n_chk++;
         if (int'(ovf_o) != m_ovf) begin
            n_bad++; $display("FAIL R3 ovf_o got %0d exp %0d at %0t", ovf_o, m_ovf, $time);
         end
         n_chk++;
         if (int'(act_o) != m_act) begin
            n_bad++; $display("FAIL R10 act_o got %0d exp %0d at %0t", act_o, m_act, $time);
         end
      end
   end

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s got %0d exp %0d", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_hi(input int n, output int hi, output int ov);
      hi = 0; ov = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         hi += int'(pwm_o);
         ov += int'(ovf_o);
      end
   endtask

   // stop, clear, set period/compare/config, start at a prescaler select
   task automatic setup(input int per, input int cmp, input int cfg, input int sel);
      wr(0, 3);
      wr(1, per);
      wr(2, cmp);
      wr(4, cfg);
      wr(0, sel << 2);
   endtask

   localparam int CFG_UNB_HI  = (2 << 3) | (1 << 2) | 1;
   localparam int CFG_UNB_LO  = (3 << 3) | (1 << 2) | 1;
   localparam int CFG_BUF_HI  = (2 << 3) | (1 << 2) | 2;

   initial begin
      int hi, ov, k, p;
      bit stable;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pwm after reset", int'(pwm_o), 0);
      chk("R1 act after reset", int'(act_o), 0);
      count_hi(20, hi, ov);
      chk("R1 stopped after reset, no wrap", ov, 0);

      setup(9, 3, CFG_UNB_HI, 0);
      idle(25);
      count_hi(10, hi, ov);
      chk("R6 high pulse width", hi, 3);
      count_hi(30, hi, ov);
      chk("R3 wraps per 30 cycles", ov, 3);

      wr(4, CFG_UNB_LO);
      idle(20);
      count_hi(10, hi, ov);
      chk("R6 low pulse, high count", hi, 7);

      wr(4, CFG_UNB_HI);
      wr(2, 0);
      idle(20);
      count_hi(10, hi, ov);
      chk("R7 zero duty", hi, 0);
      wr(2, 12);
      idle(20);
      count_hi(10, hi, ov);
      chk("R7 full duty", hi, 10);
      wr(2, 5);
      idle(12);
      count_hi(10, hi, ov);
      chk("R9 unbuffered immediate update", hi, 5);

      setup(4, 2, CFG_UNB_HI, 2);
      idle(45);
      count_hi(20, hi, ov);
      chk("R2 ratio 4 high count", hi, 8);
      chk("R2 ratio 4 wraps", ov, 1);
      setup(1, 1, CFG_UNB_HI, 7);
      idle(200);
      count_hi(128, hi, ov);
      chk("R2 select 7 is ratio 64", hi, 64);

      setup(9, 3, CFG_UNB_HI, 0);
      idle(23);
      wr(0, 1);
      p = int'(pwm_o); stable = 1;
      count_hi(20, hi, ov);
      chk("R4 stop no wraps", ov, 0);
      chk("R4 stop pin holds", hi, p * 20);

      wr(0, 2);
      k = 0;
      while (!ovf_o && k < 50) begin @(negedge clk); k++; end
      chk("R5 first wrap after clear", k, 10);

      setup(9, 3, (2 << 3) | 1, 0);
      idle(30);
      count_hi(20, hi, ov);
      chk("R8 no restore keeps pin low", hi, 0);

      setup(9, 3, CFG_UNB_LO, 0);
      idle(24);
      wr(4, 0);
      p = int'(pwm_o);
      count_hi(30, hi, ov);
      chk("R12 mode 00 pin holds", hi, p * 30);
      wr(4, (1 << 3) | (1 << 2) | 1);
      p = int'(pwm_o);
      count_hi(30, hi, ov);
      chk("R12 action bit clear pin holds", hi, p * 30);

      setup(9, 2, CFG_BUF_HI, 0);
      idle(30);
      chk("R10 no idle write, stays 0", int'(act_o), 0);
      wr(2, 4);
      idle(12);
      count_hi(10, hi, ov);
      chk("R11 write to active immediate", hi, 4);
      chk("R11 no flip scheduled", int'(act_o), 0);
      wr(3, 7);
      idle(25);
      chk("R10 flip after idle write", int'(act_o), 1);
      count_hi(10, hi, ov);
      chk("R10 new compare in use", hi, 7);
      idle(30);
      chk("R10 no further flip", int'(act_o), 1);
      wr(3, 5);
      idle(12);
      count_hi(10, hi, ov);
      chk("R11 active compare 1 immediate", hi, 5);
      chk("R11 stays on compare 1", int'(act_o), 1);
      wr(2, 1);
      idle(25);
      chk("R10 flip back to 0", int'(act_o), 0);
      count_hi(10, hi, ov);
      chk("R10 compare 0 in use", hi, 1);

      // random phase, compared each cycle against the reference
      for (int i = 0; i < 600; i++) begin
         int r;
         r = int'($urandom_range(0, 9));
         case (r)
            0: setup(int'($urandom_range(0, 12)), int'($urandom_range(0, 14)),
                     int'($urandom_range(0, 31)), int'($urandom_range(0, 3)));
            1: wr(2, int'($urandom_range(0, 14)));
            2: wr(3, int'($urandom_range(0, 14)));
            3: wr(4, int'($urandom_range(0, 31)));
            4: wr(0, int'($urandom_range(0, 7)) << 2);
            5: wr(0, 2 | (int'($urandom_range(0, 2)) << 2));
            default: idle(int'($urandom_range(1, 6)));
         endcase
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule